// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

A one-word hardware mailbox between two processors on a shared memory-mapped bus. The sending processor writes a 32-bit word into the message register. The same write latches the word and raises a level interrupt towards the receiving processor, so no further command is needed. The receiver's interrupt handler reads the word back. It then writes the acknowledge register, which lowers the interrupt and wipes the stored word to zero.

The slave side follows the usual memory-mapped register convention. It uses byte addresses, and bits [1:0] of the address are ignored. Reads return data with a fixed latency of one cycle. A read of the acknowledge offset returns the pending flag in bit 0, so software can also poll the mailbox if it needs to.

Top module: `ipi_mailbox`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the stored word to zero, lowers `irq_out` and drives `avs_readdata` to zero.
- R2: A write to word index 0 (byte offset 0x00) stores all DATA_W bits of `avs_writedata`. A later read of offset 0x00 returns that value.
- R3: `irq_out` is high in the cycle after a write to offset 0x00. No other access is needed to raise it.
- R4: `irq_out` is a level. Once raised, it stays high through idle cycles and reads until an acknowledge write.
- R5: Any write to word index 1 (byte offset 0x04), whatever its data, lowers `irq_out` and clears the stored word to zero from the next cycle.
- R6: A write to offset 0x00 while the interrupt is pending replaces the stored word and keeps `irq_out` high.
- R7: A read of offset 0x04 returns the pending flag in bit 0 and zero in all other bits.
- R8: An access to a word index other than 0 or 1 (offsets 0x08 and 0x0C with the default width) changes neither the stored word nor `irq_out`. A read there returns zero.
- R9: Read data appears in the cycle after `avs_read` is sampled high. In any cycle that does not follow a read, `avs_readdata` is zero.
- R10: Reads have no side effect. Reading offset 0x00 neither clears the word nor lowers `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| avs_address | input | ADDR_W | Byte address of the access |
| avs_write | input | 1 | Write strobe |
| avs_writedata | input | DATA_W | Write data |
| avs_read | input | 1 | Read strobe |
| avs_readdata | output | DATA_W | Read data, valid one cycle after the read |
| irq_out | output | 1 | Level interrupt to the receiving processor |

## Verification
The bench builds the block with its default widths: DATA_W of 32 and ADDR_W of 4. A 4-bit byte address gives four word slots. Two of them, 0x08 and 0x0C, are unmapped, which lets the bench check that accesses there leave the mailbox untouched. The full 32-bit data path lets all-ones and mixed patterns show up any dropped or stuck bit in both the stored word and the status word.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

  // Word slots of the register window (byte offset = slot * 4).
  localparam int unsigned SLOT_MESSAGE = 0;
  localparam int unsigned SLOT_ACK     = 1;
  localparam int unsigned LANE_BITS    = 2;

  // Decoded bus command for one cycle.
  typedef struct packed {
    logic msg_wr;
    logic ack_wr;
    logic rd_msg;
    logic rd_stat;
  } mbox_cmd_t;

endpackage

// File: rtl/ipi_mbox_decode.sv
module ipi_mbox_decode
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              read,
  output mbox_cmd_t         cmd
);
  localparam int unsigned IDX_W = ADDR_W - LANE_BITS;

  // Word slot addressed by a byte address.
  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LANE_BITS];
  endfunction

  logic [IDX_W-1:0] slot;
  logic             unused_lane;

  assign slot        = slot_of(addr);
  assign unused_lane = ^addr[LANE_BITS-1:0];

  assign cmd.msg_wr  = write && (slot == IDX_W'(SLOT_MESSAGE));
  assign cmd.ack_wr  = write && (slot == IDX_W'(SLOT_ACK));
  assign cmd.rd_msg  = read  && (slot == IDX_W'(SLOT_MESSAGE));
  assign cmd.rd_stat = read  && (slot == IDX_W'(SLOT_ACK));
endmodule

// File: rtl/ipi_mbox_store.sv
module ipi_mbox_store #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_wr,
  input  logic              ack_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] payload,
  output logic              pending
);
  // A new message wins over an acknowledge; otherwise the level holds.
  function automatic logic next_pending(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      payload <= '0;
      pending <= 1'b0;
    end else begin
      pending <= next_pending(pending, msg_wr, ack_wr);
      if (msg_wr)      payload <= wdata;
      else if (ack_wr) payload <= '0;
    end
  end
endmodule

// File: rtl/ipi_mbox_rdport.sv
module ipi_mbox_rdport #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_msg,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] payload,
  input  logic              pending,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [DATA_W-1:0] status_word(input logic flag);
    logic [DATA_W-1:0] w;
    w    = '0;
    w[0] = flag;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (rd_msg)  rdata <= payload;
    else if (rd_stat) rdata <= status_word(pending);
    else              rdata <= '0;
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] avs_address,
  input  logic              avs_write,
  input  logic [DATA_W-1:0] avs_writedata,
  input  logic              avs_read,
  output logic [DATA_W-1:0] avs_readdata,
  output logic              irq_out
);
  mbox_cmd_t         cmd;
  logic              msg_wr;
  logic              ack_wr;
  logic              rd_msg;
  logic              rd_stat;
  logic [DATA_W-1:0] payload_q;
  logic              pending_q;

  ipi_mbox_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (avs_address),
    .write (avs_write),
    .read  (avs_read),
    .cmd   (cmd)
  );

  assign msg_wr  = cmd.msg_wr;
  assign ack_wr  = cmd.ack_wr;
  assign rd_msg  = cmd.rd_msg;
  assign rd_stat = cmd.rd_stat;

  ipi_mbox_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .msg_wr  (msg_wr),
    .ack_wr  (ack_wr),
    .wdata   (avs_writedata),
    .payload (payload_q),
    .pending (pending_q)
  );

  ipi_mbox_rdport #(.DATA_W(DATA_W)) u_rdport (
    .clk     (clk),
    .rst     (rst),
    .rd_msg  (rd_msg),
    .rd_stat (rd_stat),
    .payload (payload_q),
    .pending (pending_q),
    .rdata   (avs_readdata)
  );

  assign irq_out = pending_q;
endmodule

// File: rtl/ipi_mbox_chk.sv
module ipi_mbox_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              avs_write,
  input logic              avs_read,
  input logic [DATA_W-1:0] avs_writedata,
  input logic [DATA_W-1:0] avs_readdata,
  input logic              irq_out,
  input logic              msg_wr,
  input logic              ack_wr,
  input logic              rd_stat,
  input logic [DATA_W-1:0] payload
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!irq_out && payload == '0 && avs_readdata == '0));

  // R2
  a_r2_payload_latch: assert property (@(posedge clk) disable iff (rst)
    msg_wr |=> payload == $past(avs_writedata));

  // R3
  a_r3_irq_on_message: assert property (@(posedge clk) disable iff (rst)
    msg_wr |=> irq_out);

  // R4
  a_r4_irq_level_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack_wr) |=> irq_out);

  // R5
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !msg_wr) |=> (!irq_out && payload == '0));

  // R7
  a_r7_status_bit: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> avs_readdata == {{(DATA_W-1){1'b0}}, $past(irq_out)});

  // R8
  a_r8_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (avs_write && !msg_wr && !ack_wr) |=> ($stable(payload) && $stable(irq_out)));

  // R9
  a_r9_idle_readdata: assert property (@(posedge clk) disable iff (rst)
    !avs_read |=> avs_readdata == '0);

  // R10
  a_r10_read_no_side_effect: assert property (@(posedge clk) disable iff (rst)
    !avs_write |=> ($stable(payload) && $stable(irq_out)));
endmodule

bind ipi_mailbox ipi_mbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .avs_write     (avs_write),
  .avs_read      (avs_read),
  .avs_writedata (avs_writedata),
  .avs_readdata  (avs_readdata),
  .irq_out       (irq_out),
  .msg_wr        (msg_wr),
  .ack_wr        (ack_wr),
  .rd_stat       (rd_stat),
  .payload       (payload_q)
);

// File: tb/ipi_mailbox_tb.sv
module ipi_mailbox_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NV = 18;
  localparam int VW = 1 + 4 + 32 + 32 + 1 + 4;

  // {is_read, addr, wdata, exp_readdata, exp_irq, req}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 4'h0, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 word after reset
    {1'b1, 4'h4, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 status after reset
    {1'b0, 4'h0, 32'hDEADBEEF, 32'h0,        1'b1, 4'd3},  // R3 raise
    {1'b1, 4'h0, 32'h0,        32'hDEADBEEF, 1'b1, 4'd2},  // R2 readback
    {1'b1, 4'h0, 32'h0,        32'hDEADBEEF, 1'b1, 4'd10}, // R10 reread
    {1'b1, 4'h4, 32'h0,        32'h1,        1'b1, 4'd7},  // R7 status
    {1'b0, 4'h8, 32'h12345678, 32'h0,        1'b1, 4'd8},  // R8 unmapped write
    {1'b1, 4'h0, 32'h0,        32'hDEADBEEF, 1'b1, 4'd8},  // R8 word kept
    {1'b1, 4'h8, 32'h0,        32'h0,        1'b1, 4'd8},  // R8 unmapped read
    {1'b0, 4'h0, 32'h0000A5A5, 32'h0,        1'b1, 4'd6},  // R6 overwrite
    {1'b1, 4'h0, 32'h0,        32'h0000A5A5, 1'b1, 4'd6},  // R6 new word
    {1'b0, 4'h4, 32'h0,        32'h0,        1'b0, 4'd5},  // R5 ack
    {1'b1, 4'h0, 32'h0,        32'h0,        1'b0, 4'd5},  // R5 word wiped
    {1'b1, 4'h4, 32'h0,        32'h0,        1'b0, 4'd5},  // R5 status low
    {1'b0, 4'h0, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd2},  // R2 all ones
    {1'b1, 4'h0, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2},  // R2 all ones back
    {1'b0, 4'h4, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd5},  // R5 ack with data
    {1'b0, 4'hC, 32'h00000001, 32'h0,        1'b0, 4'd8}   // R8 unmapped, no raise
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] avs_address = '0;
  logic          avs_write = 1'b0;
  logic [DW-1:0] avs_writedata = '0;
  logic          avs_read = 1'b0;
  logic [DW-1:0] avs_readdata;
  logic          irq_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_mailbox #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .avs_address   (avs_address),
    .avs_write     (avs_write),
    .avs_writedata (avs_writedata),
    .avs_read      (avs_read),
    .avs_readdata  (avs_readdata),
    .irq_out       (irq_out)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    avs_write = 1'b0;
    avs_read  = 1'b0;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    avs_address = a; avs_writedata = d; avs_write = 1'b1; avs_read = 1'b0;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic bus_rd(input logic [AW-1:0] a);
    @(negedge clk);
    avs_address = a; avs_read = 1'b1; avs_write = 1'b0;
    @(negedge clk);
    bus_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", DW'(irq_out), 32'h0);
    check("R1 readdata after reset", avs_readdata, 32'h0);

    // Table walk: each vector occupies one bus cycle, checked at the next falling edge.
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      avs_read      = v[73];
      avs_write     = ~v[73];
      avs_address   = v[72:69];
      avs_writedata = v[68:37];
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      if (v[73]) check({tag, " readdata"}, avs_readdata, v[36:5]);
      check({tag, " irq"}, DW'(irq_out), DW'(v[4]));
    end
    bus_idle();

    // R9: cycle after a read with no new read gives zero.
    bus_wr(4'h0, 32'h5A5A0F0F);
    @(negedge clk);
    avs_address = 4'h0; avs_read = 1'b1;
    @(negedge clk);
    bus_idle();
    check("R9 data one cycle after read", avs_readdata, 32'h5A5A0F0F);
    @(negedge clk);
    check("R9 zero when no read", avs_readdata, 32'h0);

    // R4: level holds over idle cycles.
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R4 irq level held", DW'(irq_out), 32'h1);
    end

    // R10: status read also leaves the flag alone.
    bus_rd(4'h4);
    check("R10 status read value", avs_readdata, 32'h1);
    check("R10 irq after status read", DW'(irq_out), 32'h1);

    // Byte lane bits ignored: 0x07 is the acknowledge slot (R5).
    bus_wr(4'h7, 32'h0);
    check("R5 ack via lane offset", DW'(irq_out), 32'h0);

    // R1: reset in the middle of a pending message.
    bus_wr(4'h0, 32'hCAFEF00D);
    check("R3 irq before reset", DW'(irq_out), 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq cleared by reset", DW'(irq_out), 32'h0);
    bus_rd(4'h0);
    check("R1 word cleared by reset", avs_readdata, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule